// File: doc/BRIEF.md
# Link Transmitter Byte Sequencer with Built-In Self-Test

This block sits at the byte-level front of a serial link transmitter. It runs on the bit-rate clock and divides it into byte periods of `BYTE_PHASES` cycles. In each byte period it emits one symbol request to a downstream 8B/10B encoder. The request is an 8-bit code point, a special-character flag, and a raw flag that tells the encoder to pass the bits through without encoding. It also drives an active-low byte-rate read strobe for an upstream FIFO. The low part of the strobe is set by counting phases, so the strobe's duty cycle does not depend on the duty cycle of the clock.

In normal operation, a low primary or secondary enable sends the parallel byte as data or as a special code. When neither enable is low, the block sends the Null pad code K28.5 so the line never goes idle. A low self-test enable selects one of two test modes. With both enables high, the block sends the D10.2/D21.5 toggle pattern. With either enable low, it sends a looping pseudo-random sequence that a matching receiver can check byte by byte. A bypass input overrides all of this and forwards the raw input bits.

Top module: `link_byte_sequencer`

## Requirements
- R1: After synchronous reset, `symByte`=0xBC, `symK`=1, `symRaw`=0, `symValid`=0 and `rdStrobe_n`=1.
- R2: `symValid` is a one-cycle pulse once every `BYTE_PHASES` clocks. The first pulse follows the `BYTE_PHASES`-th rising edge after reset is released. All inputs, including `testEn_n`, are sampled at the edge that raises `symValid`. The symbol outputs change only at that edge.
- R3: With `bypassMode`=0 and `testEn_n`=1, a low `enA_n` or `enB_n` gives `symByte`=`dataIn`, `symK`=`specialSel` and `symRaw`=0.
- R4: With `bypassMode`=0, `testEn_n`=1 and both enables high, the symbol is the Null pad: `symByte`=0xBC, `symK`=1.
- R5: Outside test mode, `rdStrobe_n` is low for exactly `LOW_PHASES` clocks, starting in the `symValid` cycle, only in a byte period whose sampled `enA_n` was low. A byte sent through `enB_n` alone, and a Null byte, leave it high.
- R6: With `testEn_n`=0 and both enables high, the symbols alternate between 0x4A (D10.2) and 0xB5 (D21.5) with `symK`=0. The first toggle byte after any other kind of byte is 0x4A. `rdStrobe_n` stays high.
- R7: With `testEn_n`=0 and either enable low, the block sends a 255-byte loop from an 8-bit LFSR. Position 0 is 0x01, and each following state is `{s[6:0], s[7]^s[5]^s[4]^s[3]}` (x^8+x^6+x^5+x^4+1). Each position sends its state with `symK`=0, except position 254, which sends the marker 0x3C with `symK`=1. The loop position is held while the block is in any other mode.
- R8: A high `specialSel` sampled in a test mode restarts the loop. A loop byte sent with it is position 0. After a toggle byte sent with it, the next loop byte is position 0.
- R9: In loop mode, `rdStrobe_n` goes low for `LOW_PHASES` clocks only in the marker byte's period. It stays high for every other loop byte.
- R10: With `bypassMode`=1, `symByte`=`dataIn`, `symK`=`specialSel` and `symRaw`=1, whatever the test and data enables are. `rdStrobe_n` follows `enA_n` as in R5. `symRaw` is 0 in all other modes.
- R11: A synchronous reset sets the loop back to position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Parallel byte from the FIFO |
| specialSel | input | 1 | Special-character select; restarts the test loop in test modes |
| enA_n | input | 1 | Primary byte enable, active low; requests a read strobe |
| enB_n | input | 1 | Secondary byte enable, active low |
| testEn_n | input | 1 | Self-test enable, active low |
| bypassMode | input | 1 | Raw bypass mode select |
| symByte | output | 8 | Code point for the encoder |
| symK | output | 1 | Special-character flag for the encoder |
| symRaw | output | 1 | Bypass flag: encoder forwards the bits unencoded |
| symValid | output | 1 | One-cycle pulse marking a new symbol |
| rdStrobe_n | output | 1 | Byte-rate FIFO read strobe, active low |

## Verification
The scoreboard runs the test loop for more than a full period. This covers the marker at position 254 and the wrap back to 0x01. A design with the wrong feedback taps, or with an off-by-one marker detect, would send the wrong byte or strobe on the wrong byte. Several restart cases are covered: one in the middle of the loop, one from the toggle mode, and a reset in the middle of the loop. A sequence that failed to restart would continue from an old position. Normal bytes between loop runs check that the position is held and not advanced. The read strobe is counted cycle by cycle in every byte. This catches a strobe on secondary-enable bytes, a strobe on loop bytes that are not the marker, and a low window of the wrong length.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] NULL_CODE = 8'hBC;
  localparam logic [BYTE_W-1:0] MARK_CODE = 8'h3C;
  localparam logic [BYTE_W-1:0] TOG_LO = 8'h4A;
  localparam logic [BYTE_W-1:0] TOG_HI = 8'hB5;
  localparam logic [BYTE_W-1:0] LFSR_SEED = 8'h01;

  typedef enum logic [2:0] {
    SEL_NULL,
    SEL_DATA,
    SEL_RAW,
    SEL_TOGGLE,
    SEL_LOOP
  } symSel_e;

  typedef struct packed {
    logic byteEdge;
    symSel_e sel;
    logic restart;
    logic primaryReq;
    logic lowWin;
  } seqCtl_t;

  function automatic logic [BYTE_W-1:0] lfsrStep(input logic [BYTE_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int unsigned BYTE_PHASES = 10,
  parameter int unsigned LOW_PHASES = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    specialSel,
  input  logic    enA_n,
  input  logic    enB_n,
  input  logic    testEn_n,
  input  logic    bypassMode,
  output seqCtl_t ctl
);
  localparam int unsigned PH_W = (BYTE_PHASES > 2) ? $clog2(BYTE_PHASES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_PHASES - 1);
  localparam logic [PH_W:0] LOW_LIM = (PH_W + 1)'(LOW_PHASES);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] phaseNext;
  logic atLast;
  symSel_e selNow;

  assign atLast = (phase == PH_LAST);
  assign phaseNext = atLast ? '0 : phase + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else phase <= phaseNext;
  end

  // mode decode: bypass > self-test > normal
  always_comb begin
    if (bypassMode) selNow = SEL_RAW;
    else if (!testEn_n) selNow = (enA_n && enB_n) ? SEL_TOGGLE : SEL_LOOP;
    else if (!enA_n || !enB_n) selNow = SEL_DATA;
    else selNow = SEL_NULL;
  end

  always_comb begin
    ctl.byteEdge = atLast;
    ctl.sel = selNow;
    ctl.restart = !bypassMode && !testEn_n && specialSel;
    ctl.primaryReq = !enA_n;
    ctl.lowWin = ({1'b0, phaseNext} < LOW_LIM);
  end
endmodule

// File: rtl/lseq_datapath.sv
module lseq_datapath
  import lseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              specialSel,
  output logic [BYTE_W-1:0] symByte,
  output logic              symK,
  output logic              symRaw,
  output logic              symValid,
  output logic              rdStrobe_n
);
  logic [BYTE_W-1:0] lfsr;
  logic [BYTE_W-1:0] curState;
  logic [BYTE_W-1:0] nextState;
  logic isMarker;
  logic togPhase;
  logic rdReq;
  logic reqNew;
  logic reqEff;
  logic [BYTE_W-1:0] byteNext;
  logic kNext;
  logic rawNext;

  assign curState = ctl.restart ? LFSR_SEED : lfsr;
  assign nextState = lfsrStep(curState);
  assign isMarker = (nextState == LFSR_SEED);

  always_comb begin
    byteNext = NULL_CODE;
    kNext = 1'b1;
    rawNext = 1'b0;
    reqNew = 1'b0;
    case (ctl.sel)
      SEL_RAW: begin
        byteNext = dataIn;
        kNext = specialSel;
        rawNext = 1'b1;
        reqNew = ctl.primaryReq;
      end
      SEL_DATA: begin
        byteNext = dataIn;
        kNext = specialSel;
        reqNew = ctl.primaryReq;
      end
      SEL_TOGGLE: begin
        byteNext = togPhase ? TOG_HI : TOG_LO;
        kNext = 1'b0;
      end
      SEL_LOOP: begin
        byteNext = isMarker ? MARK_CODE : curState;
        kNext = isMarker;
        reqNew = isMarker;
      end
      default: begin
        byteNext = NULL_CODE;
        kNext = 1'b1;
      end
    endcase
  end

  assign reqEff = ctl.byteEdge ? reqNew : rdReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= LFSR_SEED;
      togPhase <= 1'b0;
      rdReq <= 1'b0;
      symByte <= NULL_CODE;
      symK <= 1'b1;
      symRaw <= 1'b0;
      symValid <= 1'b0;
      rdStrobe_n <= 1'b1;
    end else begin
      symValid <= ctl.byteEdge;
      rdStrobe_n <= !(reqEff && ctl.lowWin);
      if (ctl.byteEdge) begin
        symByte <= byteNext;
        symK <= kNext;
        symRaw <= rawNext;
        rdReq <= reqNew;
        togPhase <= (ctl.sel == SEL_TOGGLE) ? ~togPhase : 1'b0;
        if (ctl.sel == SEL_LOOP) lfsr <= nextState;
        else if (ctl.restart) lfsr <= LFSR_SEED;
      end
    end
  end
endmodule

// File: rtl/link_byte_sequencer.sv
module link_byte_sequencer
  import lseq_pkg::*;
#(
  parameter int unsigned BYTE_PHASES = 10,
  parameter int unsigned LOW_PHASES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] dataIn,
  input  logic       specialSel,
  input  logic       enA_n,
  input  logic       enB_n,
  input  logic       testEn_n,
  input  logic       bypassMode,
  output logic [7:0] symByte,
  output logic       symK,
  output logic       symRaw,
  output logic       symValid,
  output logic       rdStrobe_n
);
  seqCtl_t ctl;

  lseq_ctrl #(
    .BYTE_PHASES(BYTE_PHASES),
    .LOW_PHASES(LOW_PHASES)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .specialSel(specialSel),
    .enA_n(enA_n),
    .enB_n(enB_n),
    .testEn_n(testEn_n),
    .bypassMode(bypassMode),
    .ctl(ctl)
  );

  lseq_datapath u_dp (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .dataIn(dataIn),
    .specialSel(specialSel),
    .symByte(symByte),
    .symK(symK),
    .symRaw(symRaw),
    .symValid(symValid),
    .rdStrobe_n(rdStrobe_n)
  );
endmodule

// File: rtl/link_byte_sequencer_chk.sv
module link_byte_sequencer_chk
  import lseq_pkg::*;
#(
  parameter int unsigned BYTE_PHASES = 10,
  parameter int unsigned LOW_PHASES = 6
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] dataIn,
  input logic       specialSel,
  input logic       bypassMode,
  input logic [7:0] symByte,
  input logic       symK,
  input logic       symRaw,
  input logic       symValid,
  input logic       rdStrobe_n
);
  logic [15:0] gapCnt;
  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
      lowRun <= '0;
    end else begin
      gapCnt <= symValid ? 16'd1 : gapCnt + 16'd1;
      lowRun <= rdStrobe_n ? 16'd0 : lowRun + 16'd1;
    end
  end

  p_byte_period_r2: assert property (@(posedge clk) disable iff (rst)
    symValid |-> gapCnt == 16'(BYTE_PHASES));

  p_symbol_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !symValid |-> $stable(symByte) && $stable(symK) && $stable(symRaw));

  p_null_code_r4: assert property (@(posedge clk) disable iff (rst)
    symValid && !symRaw && symK |-> symByte == NULL_CODE || symByte == MARK_CODE
      || symByte == $past(dataIn));

  p_bypass_pass_r10: assert property (@(posedge clk) disable iff (rst)
    symValid && $past(bypassMode) |->
      symRaw && symByte == $past(dataIn) && symK == $past(specialSel));

  p_strobe_start_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rdStrobe_n) |-> symValid);

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst)
    lowRun <= 16'(LOW_PHASES));
endmodule

bind link_byte_sequencer link_byte_sequencer_chk #(
  .BYTE_PHASES(BYTE_PHASES),
  .LOW_PHASES(LOW_PHASES)
) u_chk (
  .clk(clk),
  .rst(rst),
  .dataIn(dataIn),
  .specialSel(specialSel),
  .bypassMode(bypassMode),
  .symByte(symByte),
  .symK(symK),
  .symRaw(symRaw),
  .symValid(symValid),
  .rdStrobe_n(rdStrobe_n)
);

// File: tb/sim_link_byte_sequencer.sv
module sim_link_byte_sequencer;
  localparam int PH = 10;
  localparam int LOW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [7:0] dataIn;
  logic specialSel, enA_n, enB_n, testEn_n, bypassMode;
  logic [7:0] symByte;
  logic symK, symRaw, symValid, rdStrobe_n;

  link_byte_sequencer #(.BYTE_PHASES(PH), .LOW_PHASES(LOW)) u0 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .specialSel(specialSel),
    .enA_n(enA_n), .enB_n(enB_n), .testEn_n(testEn_n), .bypassMode(bypassMode),
    .symByte(symByte), .symK(symK), .symRaw(symRaw), .symValid(symValid),
    .rdStrobe_n(rdStrobe_n)
  );

  typedef struct {
    logic [7:0] b;
    logic k;
    logic raw;
    logic low;
    string tag;
  } exp_t;

  exp_t q[$];
  int nChecks = 0;
  int nFail = 0;
  logic [7:0] refLfsr = 8'h01;
  logic refTog = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] stepRef(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // drive one byte period and queue its expected symbol
  task automatic sendByte(input logic [7:0] d, input logic sc, input logic a_n,
                          input logic b_n, input logic t_n, input logic byp,
                          input string tag);
    exp_t e;
    logic [7:0] cur, nxt;
    e.tag = tag;
    if (byp) begin
      e.b = d; e.k = sc; e.raw = 1'b1; e.low = !a_n; refTog = 1'b0;
    end else if (!t_n) begin
      e.raw = 1'b0;
      if (a_n && b_n) begin
        e.b = refTog ? 8'hB5 : 8'h4A; e.k = 1'b0; e.low = 1'b0;
        refTog = !refTog;
        if (sc) refLfsr = 8'h01;
      end else begin
        cur = sc ? 8'h01 : refLfsr;
        nxt = stepRef(cur);
        if (nxt == 8'h01) begin
          e.b = 8'h3C; e.k = 1'b1; e.low = 1'b1; e.tag = "R9";
        end else begin
          e.b = cur; e.k = 1'b0; e.low = 1'b0;
        end
        refLfsr = nxt;
        refTog = 1'b0;
      end
    end else begin
      refTog = 1'b0; e.raw = 1'b0;
      if (!a_n || !b_n) begin
        e.b = d; e.k = sc; e.low = !a_n;
      end else begin
        e.b = 8'hBC; e.k = 1'b1; e.low = 1'b0;
      end
    end
    dataIn = d; specialSel = sc; enA_n = a_n; enB_n = b_n;
    testEn_n = t_n; bypassMode = byp;
    q.push_back(e);
    @(negedge clk);
    while (!symValid) @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    q.delete();
    refLfsr = 8'h01;
    refTog = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(symByte == 8'hBC, "R1", "reset symByte", symByte, 8'hBC);
    check(symK == 1'b1, "R1", "reset symK", symK, 1);
    check(symRaw == 1'b0, "R1", "reset symRaw", symRaw, 0);
    check(symValid == 1'b0, "R1", "reset symValid", symValid, 0);
    check(rdStrobe_n == 1'b1, "R1", "reset rdStrobe_n", rdStrobe_n, 1);
    #1;
  endtask

  // monitor / scoreboard
  int gapCnt = 0;
  int lowCnt = 0;
  bit havePrev = 0;
  logic prevLow = 0;
  string prevTag = "";

  always @(negedge clk) begin
    if (rst) begin
      gapCnt = 0; lowCnt = 0; havePrev = 0;
    end else begin
      gapCnt++;
      if (symValid) begin
        exp_t e;
        if (havePrev)
          check(lowCnt == (prevLow ? LOW : 0), "R5", {prevTag, " strobe low cycles"},
                lowCnt, prevLow ? LOW : 0);
        check(gapCnt == PH, "R2", "byte period", gapCnt, PH);
        gapCnt = 0;
        lowCnt = rdStrobe_n ? 0 : 1;
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected symbol", symByte, 0);
          havePrev = 0;
        end else begin
          e = q.pop_front();
          check(symByte == e.b, e.tag, "symByte", symByte, e.b);
          check(symK == e.k, e.tag, "symK", symK, e.k);
          check(symRaw == e.raw, "R10", {e.tag, " symRaw"}, symRaw, e.raw);
          havePrev = 1; prevLow = e.low; prevTag = e.tag;
        end
      end else if (!rdStrobe_n) begin
        lowCnt++;
      end
    end
  end

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    dataIn = 8'h00; specialSel = 0; enA_n = 1; enB_n = 1; testEn_n = 1; bypassMode = 0;
    doReset();
    // R3 / R5 normal data
    sendByte(8'h11, 0, 0, 1, 1, 0, "R3");
    sendByte(8'hF7, 1, 0, 1, 1, 0, "R3");
    sendByte(8'h5A, 0, 1, 0, 1, 0, "R5");
    sendByte(8'h00, 0, 1, 1, 1, 0, "R4");
    sendByte(8'h33, 1, 1, 1, 1, 0, "R4");
    sendByte(8'hA5, 0, 0, 0, 1, 0, "R3");
    // R10 bypass overrides test and enables
    sendByte(8'hC3, 1, 1, 1, 0, 1, "R10");
    sendByte(8'h3C, 0, 0, 1, 0, 1, "R10");
    sendByte(8'h7E, 0, 1, 1, 1, 1, "R10");
    // R6 toggle
    for (int i = 0; i < 5; i++) sendByte(8'(i * 37), 0, 1, 1, 0, 0, "R6");
    sendByte(8'h00, 0, 1, 1, 1, 0, "R4");
    for (int i = 0; i < 3; i++) sendByte(8'hFF, 0, 1, 1, 0, 0, "R6");
    // R7 loop, mid restart R8, hold across normal bytes
    for (int i = 0; i < 20; i++) sendByte(8'(i), 0, 0, 1, 0, 0, "R7");
    sendByte(8'h99, 1, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 10; i++) sendByte(8'(i), 0, 1, 0, 0, 0, "R7");
    sendByte(8'h21, 0, 0, 1, 1, 0, "R3");
    sendByte(8'h00, 0, 1, 1, 1, 0, "R4");
    sendByte(8'h00, 1, 1, 1, 0, 1, "R10");
    for (int i = 0; i < 250; i++) sendByte(8'(i), 0, 0, 0, 0, 0, "R7");
    // restart from toggle mode
    sendByte(8'h00, 1, 1, 1, 0, 0, "R8");
    sendByte(8'h00, 0, 0, 1, 0, 0, "R8");
    sendByte(8'h00, 0, 0, 1, 0, 0, "R8");
    // reset in mid loop
    for (int i = 0; i < 5; i++) sendByte(8'h00, 0, 0, 1, 0, 0, "R7");
    doReset();
    for (int i = 0; i < 3; i++) sendByte(8'h00, 0, 0, 1, 0, 0, "R11");
    sendByte(8'h00, 0, 1, 1, 1, 0, "R4");
    sendByte(8'h00, 0, 1, 1, 1, 0, "R4");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule